// File: doc/BRIEF.md
# Exception and Interrupt Acceptance Gate

This block sits beside a processor's exception logic and decides, on every clock, what happens to the event that is asking for service. An exception arrives with a kind and a cause code. Ordinary and nonmaskable interrupt requests arrive as levels. The gate reads the status block bit and a sleep flag, and it produces one of three results: the event is taken, it is held, or it is turned into a manual reset.

Two interrupt requests are captured in sticky pending registers. A held interrupt is therefore not lost while the block bit is set, and it is serviced once the block bit clears.

Inside the delay slot of a return-from-exception instruction, the status value both before and after the restore are visible. The gate chooses between them according to the kind of exception. Results are registered, so every event taken in cycle N shows as a one-cycle pulse after the edge that ends cycle N.

Top module: `evt_accept_gate`

## Requirements
- R1: After reset, `take_pulse`, `mreset_pulse` and `save_ok` are 0 and `evt_code` is 0.
- R2: An exception of kind 00, 01 or 11 that is judged blocked gives `mreset_pulse`=1 and `evt_code`=0x020 one edge later, with `take_pulse`=0.
- R3: `save_ok` (permission to write the saved PC and status) is 1 only together with `take_pulse`, and it is never 1 with `mreset_pulse`.
- R4: An exception that is judged unblocked gives `take_pulse`=1, `save_ok`=1 and `evt_code` equal to its `exc_code` one edge later.
- R5: An ordinary interrupt raised while `blk_now`=1 and `sleep_mode`=0 is held. It is taken with `evt_code`=`irq_code` on the edge after `blk_now` returns to 0.
- R6: A nonmaskable interrupt raised while blocked and not sleeping is held when `nmi_pass`=0. It is taken with `evt_code`=NMI_CODE (0x1C0 by default) when `nmi_pass`=1.
- R7: With `sleep_mode`=1, a pending interrupt is taken even when `blk_now`=1.
- R8: A user break (kind 10) produces no pulse when `rte_slot`=1 or `blk_now`=1. Otherwise it is taken like any other exception.
- R9: When `rte_slot`=1, an instruction-access exception (kind 01) is judged with `blk_prev`, and every other exception kind is judged with `blk_now`.
- R10: A pending interrupt is set by a rising request. It is cleared when it is taken, so a request that stays high is served once. It is also cleared when the request drops before it is taken.
- R11: At most one of `take_pulse` and `mreset_pulse` is 1 in any cycle. Exceptions win over interrupts, and the nonmaskable interrupt wins over the ordinary one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| blk_now | input | 1 | Block bit of the current (restored) status |
| blk_prev | input | 1 | Block bit of the status in force before a return restore |
| sleep_mode | input | 1 | Core is sleeping |
| nmi_pass | input | 1 | Software setting: accept the nonmaskable interrupt while blocked |
| rte_slot | input | 1 | Current instruction is in the delay slot of a return-from-exception |
| exc_valid | input | 1 | An exception is raised this cycle |
| exc_kind | input | 2 | 00 general, 01 instruction access, 10 user break, 11 other |
| exc_code | input | CODE_W | Cause code of the exception |
| nmi_req | input | 1 | Nonmaskable interrupt request level |
| irq_req | input | 1 | Ordinary interrupt request level |
| irq_code | input | CODE_W | Cause code of the ordinary interrupt |
| take_pulse | output | 1 | Event taken (one cycle) |
| mreset_pulse | output | 1 | Manual reset request (one cycle) |
| save_ok | output | 1 | Saved PC and status may be written |
| evt_code | output | CODE_W | Code for the event-cause register |

## Verification
The hardest situation to reach is the delay slot of a return-from-exception. There the block bits before and after the restore differ, so the same cycle must mark one exception kind as blocked and another as open. The stimulus drives `rte_slot` with `blk_prev` and `blk_now` set to opposite values. It then raises an instruction-access exception and a general exception in turn, and repeats this with the two bits swapped.

A second hard case is the priority ordering. Both interrupts are first allowed to become pending. An exception is then raised in the cycle in which they would be granted, so that three taken events follow one another on successive edges.

// File: rtl/evt_gate_pkg.sv
package evt_gate_pkg;

  typedef enum logic [1:0] {
    EK_GENERAL = 2'b00,
    EK_IFETCH  = 2'b01,
    EK_UBREAK  = 2'b10,
    EK_OTHER   = 2'b11
  } exc_kind_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EXC,
    SEL_NMI,
    SEL_IRQ
  } sel_e;

  // Which block bit governs an exception: instruction-access faults in the
  // return delay slot look at the status from before the restore.
  function automatic logic judge_block(exc_kind_e k, logic in_slot,
                                       logic blk_before, logic blk_after);
    return (in_slot && (k == EK_IFETCH)) ? blk_before : blk_after;
  endfunction

  // An interrupt may pass when unblocked, when sleeping, or when bypassed.
  function automatic logic irq_open(logic blk, logic sleeping, logic bypass);
    return !blk || sleeping || bypass;
  endfunction

  // A user break is dropped in the return delay slot or while blocked.
  function automatic logic ubreak_drop(exc_kind_e k, logic in_slot, logic blk);
    return (k == EK_UBREAK) && (in_slot || blk);
  endfunction

endpackage

// File: rtl/evt_pend_hold.sv
module evt_pend_hold #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] grant,
  output logic [N-1:0] pend
);

  logic [N-1:0] req_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic rise_w;
    assign rise_w = req[i] && !req_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        req_q[i] <= req[i];
        if (!req[i] || grant[i])
          pend[i] <= 1'b0;
        else if (rise_w)
          pend[i] <= 1'b1;
      end
    end

    // R10
    grant_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |=> !pend[i]);

    // R10
    withdraw_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req[i] |=> !pend[i]);
  end

endmodule

// File: rtl/evt_exc_qual.sv
module evt_exc_qual
  import evt_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exc_valid,
  input  logic [1:0] exc_kind,
  input  logic       rte_slot,
  input  logic       blk_now,
  input  logic       blk_prev,
  output logic       exc_take,
  output logic       exc_reset
);

  exc_kind_e kind_w;
  logic      drop_w;
  logic      eff_blk_w;

  assign kind_w    = exc_kind_e'(exc_kind);
  assign drop_w    = ubreak_drop(kind_w, rte_slot, blk_now);
  assign eff_blk_w = judge_block(kind_w, rte_slot, blk_prev, blk_now);

  always_comb begin
    exc_take  = 1'b0;
    exc_reset = 1'b0;
    if (exc_valid && !drop_w) begin
      if (eff_blk_w) exc_reset = 1'b1;
      else           exc_take  = 1'b1;
    end
  end

  // R8
  ubreak_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && kind_w == EK_UBREAK && rte_slot) |-> !(exc_take || exc_reset));

  // R9
  ifetch_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && kind_w == EK_IFETCH && rte_slot) |-> (exc_reset == blk_prev));

  // R11
  exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_take && exc_reset));

endmodule

// File: rtl/evt_select.sv
module evt_select
  import evt_gate_pkg::*;
#(
  parameter int                 CODE_W   = 12,
  parameter logic [CODE_W-1:0]  NMI_CODE = 'h1C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_take,
  input  logic              exc_reset,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              nmi_pend,
  input  logic              irq_pend,
  input  logic [CODE_W-1:0] irq_code,
  input  logic              blk_now,
  input  logic              sleep_mode,
  input  logic              nmi_pass,
  output logic              grant_nmi,
  output logic              grant_irq,
  output logic              take_pulse,
  output logic              mreset_pulse,
  output logic              save_ok,
  output logic [CODE_W-1:0] evt_code
);

  localparam logic [CODE_W-1:0] MRESET_CODE = CODE_W'(32'h020);

  sel_e              sel_w;
  logic              nmi_ok_w;
  logic              irq_ok_w;
  logic [CODE_W-1:0] code_w;

  assign nmi_ok_w = nmi_pend && irq_open(blk_now, sleep_mode, nmi_pass);
  assign irq_ok_w = irq_pend && irq_open(blk_now, sleep_mode, 1'b0);

  always_comb begin
    if (exc_take || exc_reset) sel_w = SEL_EXC;
    else if (nmi_ok_w)         sel_w = SEL_NMI;
    else if (irq_ok_w)         sel_w = SEL_IRQ;
    else                       sel_w = SEL_NONE;
  end

  assign grant_nmi = (sel_w == SEL_NMI);
  assign grant_irq = (sel_w == SEL_IRQ);

  always_comb begin
    case (sel_w)
      SEL_EXC: code_w = exc_reset ? MRESET_CODE : exc_code;
      SEL_NMI: code_w = NMI_CODE;
      SEL_IRQ: code_w = irq_code;
      default: code_w = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_pulse   <= 1'b0;
      mreset_pulse <= 1'b0;
      save_ok      <= 1'b0;
      evt_code     <= '0;
    end else begin
      take_pulse   <= (sel_w != SEL_NONE) && !exc_reset;
      mreset_pulse <= exc_reset;
      save_ok      <= (sel_w != SEL_NONE) && !exc_reset;
      evt_code     <= code_w;
    end
  end

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_irq |-> (!blk_now || sleep_mode));

  // R6
  nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_nmi && blk_now && !sleep_mode) |-> nmi_pass);

  // R11
  exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take || exc_reset) |-> !(grant_nmi || grant_irq));

  // R11
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_pulse, mreset_pulse}));

  // R2
  reset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreset_pulse |-> (evt_code == MRESET_CODE));

  // R3
  save_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_ok |-> (take_pulse && !mreset_pulse));

endmodule

// File: rtl/evt_accept_gate.sv
module evt_accept_gate #(
  parameter int                CODE_W   = 12,
  parameter logic [CODE_W-1:0] NMI_CODE = 'h1C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_now,
  input  logic              blk_prev,
  input  logic              sleep_mode,
  input  logic              nmi_pass,
  input  logic              rte_slot,
  input  logic              exc_valid,
  input  logic [1:0]        exc_kind,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              nmi_req,
  input  logic              irq_req,
  input  logic [CODE_W-1:0] irq_code,
  output logic              take_pulse,
  output logic              mreset_pulse,
  output logic              save_ok,
  output logic [CODE_W-1:0] evt_code
);

  localparam int NSRC    = 2;
  localparam int IDX_IRQ = 0;
  localparam int IDX_NMI = 1;

  logic [NSRC-1:0] req_w;
  logic [NSRC-1:0] grant_w;
  logic [NSRC-1:0] pend_w;
  logic            exc_take_w;
  logic            exc_reset_w;
  logic            grant_nmi_w;
  logic            grant_irq_w;

  assign req_w[IDX_IRQ]   = irq_req;
  assign req_w[IDX_NMI]   = nmi_req;
  assign grant_w[IDX_IRQ] = grant_irq_w;
  assign grant_w[IDX_NMI] = grant_nmi_w;

  evt_pend_hold #(.N(NSRC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_w),
    .grant (grant_w),
    .pend  (pend_w)
  );

  evt_exc_qual u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_valid (exc_valid),
    .exc_kind  (exc_kind),
    .rte_slot  (rte_slot),
    .blk_now   (blk_now),
    .blk_prev  (blk_prev),
    .exc_take  (exc_take_w),
    .exc_reset (exc_reset_w)
  );

  evt_select #(.CODE_W(CODE_W), .NMI_CODE(NMI_CODE)) u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_take     (exc_take_w),
    .exc_reset    (exc_reset_w),
    .exc_code     (exc_code),
    .nmi_pend     (pend_w[IDX_NMI]),
    .irq_pend     (pend_w[IDX_IRQ]),
    .irq_code     (irq_code),
    .blk_now      (blk_now),
    .sleep_mode   (sleep_mode),
    .nmi_pass     (nmi_pass),
    .grant_nmi    (grant_nmi_w),
    .grant_irq    (grant_irq_w),
    .take_pulse   (take_pulse),
    .mreset_pulse (mreset_pulse),
    .save_ok      (save_ok),
    .evt_code     (evt_code)
  );

  // R10
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w));

endmodule

// File: tb/sim_evt_accept_gate.sv
module sim_evt_accept_gate;

  localparam int CW = 12;
  localparam logic [CW-1:0] NMI_C = 12'h1C0;
  localparam logic [CW-1:0] RST_C = 12'h020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_now = 0, blk_prev = 0, sleep_mode = 0, nmi_pass = 0, rte_slot = 0;
  logic exc_valid = 0;
  logic [1:0] exc_kind = 2'b00;
  logic [CW-1:0] exc_code = '0, irq_code = '0;
  logic nmi_req = 0, irq_req = 0;
  logic take_pulse, mreset_pulse, save_ok;
  logic [CW-1:0] evt_code;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  evt_accept_gate #(.CODE_W(CW), .NMI_CODE(NMI_C)) u0 (
    .clk(clk), .rst_n(rst_n), .blk_now(blk_now), .blk_prev(blk_prev),
    .sleep_mode(sleep_mode), .nmi_pass(nmi_pass), .rte_slot(rte_slot),
    .exc_valid(exc_valid), .exc_kind(exc_kind), .exc_code(exc_code),
    .nmi_req(nmi_req), .irq_req(irq_req), .irq_code(irq_code),
    .take_pulse(take_pulse), .mreset_pulse(mreset_pulse),
    .save_ok(save_ok), .evt_code(evt_code)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulses(string req, logic tk, logic mr, logic sv);
    chk(req, "take_pulse", 32'(take_pulse), 32'(tk));
    chk(req, "mreset_pulse", 32'(mreset_pulse), 32'(mr));
    chk(req, "save_ok", 32'(save_ok), 32'(sv));
  endtask

  task automatic raise_exc(logic [1:0] k, logic [CW-1:0] c);
    exc_valid = 1'b1; exc_kind = k; exc_code = c;
    tick();
    exc_valid = 1'b0;
  endtask

  task automatic t_reset();
    pulses("R1", 1'b0, 1'b0, 1'b0);
    chk("R1", "evt_code", 32'(evt_code), 32'h0);
  endtask

  task automatic t_blocked_exc();
    blk_now = 1;
    raise_exc(2'b00, 12'h1A0);
    pulses("R2", 1'b0, 1'b1, 1'b0);
    chk("R2", "evt_code", 32'(evt_code), 32'(RST_C));
    chk("R3", "save_ok on reset", 32'(save_ok), 32'h0);
    raise_exc(2'b11, 12'h1B0);
    pulses("R2", 1'b0, 1'b1, 1'b0);
    blk_now = 0;
    tick();
  endtask

  task automatic t_open_exc();
    raise_exc(2'b00, 12'h0E0);
    pulses("R4", 1'b1, 1'b0, 1'b1);
    chk("R4", "evt_code", 32'(evt_code), 32'h0E0);
    tick();
    pulses("R4", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_irq_hold();
    blk_now = 1; irq_code = 12'h3C0; irq_req = 1;
    tick();
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5", "held take_pulse", 32'(take_pulse), 32'h0);
    end
    blk_now = 0;
    tick();
    pulses("R5", 1'b1, 1'b0, 1'b1);
    chk("R5", "evt_code", 32'(evt_code), 32'h3C0);
    tick();
    chk("R10", "served once", 32'(take_pulse), 32'h0);
    irq_req = 0;
    tick();
  endtask

  task automatic t_nmi_cfg();
    blk_now = 1; nmi_pass = 0; nmi_req = 1;
    tick();
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6", "nmi held", 32'(take_pulse), 32'h0);
    end
    nmi_pass = 1;
    tick();
    chk("R6", "nmi taken", 32'(take_pulse), 32'h1);
    chk("R6", "evt_code", 32'(evt_code), 32'(NMI_C));
    nmi_req = 0; nmi_pass = 0; blk_now = 0;
    tick();
  endtask

  task automatic t_sleep();
    blk_now = 1; sleep_mode = 1; irq_code = 12'h2A0; irq_req = 1;
    tick();
    tick();
    chk("R7", "sleep take", 32'(take_pulse), 32'h1);
    chk("R7", "evt_code", 32'(evt_code), 32'h2A0);
    irq_req = 0; sleep_mode = 0; blk_now = 0;
    tick();
  endtask

  task automatic t_ubreak();
    rte_slot = 1;
    raise_exc(2'b10, 12'h1E0);
    pulses("R8", 1'b0, 1'b0, 1'b0);
    rte_slot = 0; blk_now = 1;
    raise_exc(2'b10, 12'h1E0);
    pulses("R8", 1'b0, 1'b0, 1'b0);
    blk_now = 0;
    raise_exc(2'b10, 12'h1E0);
    chk("R8", "break taken outside slot", 32'(take_pulse), 32'h1);
    chk("R8", "evt_code", 32'(evt_code), 32'h1E0);
    tick();
  endtask

  task automatic t_rte_slot();
    rte_slot = 1; blk_prev = 1; blk_now = 0;
    raise_exc(2'b01, 12'h0A0);
    pulses("R9", 1'b0, 1'b1, 1'b0);
    raise_exc(2'b00, 12'h0B0);
    pulses("R9", 1'b1, 1'b0, 1'b1);
    blk_prev = 0; blk_now = 1;
    raise_exc(2'b01, 12'h0A0);
    pulses("R9", 1'b1, 1'b0, 1'b1);
    chk("R9", "evt_code", 32'(evt_code), 32'h0A0);
    raise_exc(2'b00, 12'h0B0);
    pulses("R9", 1'b0, 1'b1, 1'b0);
    rte_slot = 0; blk_now = 0;
    tick();
  endtask

  task automatic t_withdraw();
    blk_now = 1; irq_req = 1;
    tick(); tick();
    irq_req = 0;
    tick();
    blk_now = 0;
    tick();
    chk("R10", "withdrawn", 32'(take_pulse), 32'h0);
    tick();
    chk("R10", "withdrawn", 32'(take_pulse), 32'h0);
  endtask

  task automatic t_priority();
    irq_code = 12'h3F0; irq_req = 1; nmi_req = 1;
    tick();
    raise_exc(2'b00, 12'h0C0);
    chk("R11", "exception first", 32'(evt_code), 32'h0C0);
    tick();
    chk("R11", "nmi second", 32'(evt_code), 32'(NMI_C));
    chk("R11", "take", 32'(take_pulse), 32'h1);
    tick();
    chk("R11", "irq third", 32'(evt_code), 32'h3F0);
    tick();
    chk("R11", "idle after", 32'(take_pulse), 32'h0);
    irq_req = 0; nmi_req = 0;
    tick();
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_blocked_exc();
    t_open_exc();
    t_irq_hold();
    t_nmi_cfg();
    t_sleep();
    t_ubreak();
    t_rte_slot();
    t_withdraw();
    t_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule